// File: doc/BRIEF.md
# Gzip Stream Framer with CRC32 and 32-bit Word Packer

This block turns a stream of already-compressed bytes into one complete gzip member per packet. Each packet opens with a fixed 10-byte header and carries the compressed bytes unchanged. It closes with an 8-byte trailer that holds the CRC32 and the byte count of the uncompressed data. The finished byte sequence is packed little-endian into 32-bit beats on an AXI-Stream master. Byte enables (tkeep) mark a short final beat.

The uncompressed data reaches the block on its own side stream, which has no backpressure. The block folds each raw byte into a running CRC32 and a length counter. On the last raw byte of a packet it snapshots both values and starts the running registers afresh for the next packet. The trailer is sent only once that snapshot exists. The compressed stream uses a valid/ready handshake and marks its final byte. The framer starts a packet when the first compressed byte is offered. The side stream must not finish a second packet before the trailer of the first has been taken.

Top module: `gz_stream_framer`

## Requirements
- R1: A packet starts when a compressed byte is offered while the block is idle. The first 10 bytes are 1F 8B 08 00 00 00 00 00 00 FF, in that order, and no compressed byte is accepted before they have been queued.
- R2: After the header, the compressed bytes are emitted unchanged and in arrival order, up to and including the byte flagged as last.
- R3: After the payload come four bytes holding the CRC32 of the packet's raw bytes, least-significant byte first. The CRC uses the reflected polynomial EDB88320, a start value of FFFFFFFF and a final inversion, so the raw bytes "123456789" give CBF43926.
- R4: The last four bytes of a packet are the raw byte count modulo 2^32, least-significant byte first.
- R5: Each beat carries stream bytes in order, with the earliest byte in tdata[7:0] and the latest in tdata[31:24].
- R6: tkeep is 1111 and tlast is 0 on every beat except the final one. The final beat has tlast=1 and tkeep of 0001, 0011, 0111 or 1111 when the packet's total byte count modulo 4 is 1, 2, 3 or 0.
- R7: A beat moves only when tvalid and tready are both high. While tvalid is high and tready is low, tvalid, tdata, tkeep and tlast stay unchanged.
- R8: The CRC and length start over for every packet, so back-to-back packets each carry a trailer computed only from their own raw bytes.
- R9: If the raw side stream ends after the compressed stream, the trailer waits for it. A raw last byte that arrives in the same cycle as the final compressed byte is accepted is still counted in that packet's trailer.
- R10: After reset, m_tvalid_o and cmp_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_valid_i | input | 1 | Raw byte present on the side stream |
| raw_data_i | input | 8 | Raw (uncompressed) byte |
| raw_last_i | input | 1 | Final raw byte of the packet |
| cmp_valid_i | input | 1 | Compressed byte offered |
| cmp_data_i | input | 8 | Compressed byte |
| cmp_last_i | input | 1 | Final compressed byte of the packet |
| cmp_ready_o | output | 1 | Compressed byte accepted this cycle |
| m_tready_i | input | 1 | Downstream ready |
| m_tvalid_o | output | 1 | Output beat valid |
| m_tdata_o | output | 32 | Output beat, little-endian bytes |
| m_tkeep_o | output | 4 | Byte enables of the beat |
| m_tlast_o | output | 1 | Final beat of the gzip packet |

## Verification
Two functions can land in one cycle: the payload's final byte entering the packer, and the raw side stream's last byte being folded into the CRC and captured as the trailer snapshot. The bench provokes this by holding back the last raw byte until the cycle in which it sees the final compressed byte being accepted, and then presenting it in that same cycle. The outcome is judged at the ports: the trailer bytes must match a CRC and length computed in the bench over every raw byte, including that last one. A second case lets the raw stream end long after the payload, so the trailer has to wait for the snapshot.

// File: rtl/gz_frame_pkg.sv
package gz_frame_pkg;
  localparam int HDR_BYTES = 10;
  localparam int FTR_BYTES = 8;
  localparam int IDX_W     = $clog2(HDR_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_FTR} frame_st_e;

  function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    return 8'h1F;
      4'd1:    return 8'h8B;
      4'd2:    return 8'h08;
      4'd9:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d,
                                             input logic [31:0] poly);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/gz_crc_len.sv
module gz_crc_len
  import gz_frame_pkg::*;
#(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        raw_valid_i,
  input  logic [7:0]  raw_data_i,
  input  logic        raw_last_i,
  input  logic        take_i,
  output logic        snap_vld_o,
  output logic [31:0] snap_crc_o,
  output logic [31:0] snap_len_o
);
  logic [31:0] crc_q, len_q, crc_n, len_n;
  logic        snap_vld_q;
  logic [31:0] snap_crc_q, snap_len_q;

  assign crc_n = crc32_step(crc_q, raw_data_i, POLY);
  assign len_n = len_q + 32'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q      <= '1;
      len_q      <= '0;
      snap_vld_q <= 1'b0;
      snap_crc_q <= '0;
      snap_len_q <= '0;
    end else begin
      if (take_i) snap_vld_q <= 1'b0;
      if (raw_valid_i) begin
        if (raw_last_i) begin
          // packet done: freeze result, restart running state
          snap_crc_q <= ~crc_n;
          snap_len_q <= len_n;
          snap_vld_q <= 1'b1;
          crc_q      <= '1;
          len_q      <= '0;
        end else begin
          crc_q <= crc_n;
          len_q <= len_n;
        end
      end
    end
  end

  assign snap_vld_o = snap_vld_q;
  assign snap_crc_o = snap_crc_q;
  assign snap_len_o = snap_len_q;

  // R8
  raw_no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_valid_i && raw_last_i && snap_vld_q) |-> take_i);

  // R3
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_vld_q && !take_i && !(raw_valid_i && raw_last_i))
      |=> (snap_vld_q && $stable(snap_crc_q) && $stable(snap_len_q)));
endmodule

// File: rtl/gz_frame_seq.sv
module gz_frame_seq
  import gz_frame_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmp_valid_i,
  input  logic [7:0]  cmp_data_i,
  input  logic        cmp_last_i,
  output logic        cmp_ready_o,
  input  logic        snap_vld_i,
  input  logic [31:0] snap_crc_i,
  input  logic [31:0] snap_len_i,
  output logic        take_o,
  output logic        byte_v_o,
  output logic [7:0]  byte_d_o,
  output logic        byte_last_o,
  input  logic        byte_rdy_i
);
  frame_st_e        st_q;
  logic [IDX_W-1:0] idx_q;
  logic [63:0]      ftr_w;

  assign ftr_w = {snap_len_i, snap_crc_i};

  always_comb begin
    byte_v_o    = 1'b0;
    byte_d_o    = 8'h00;
    byte_last_o = 1'b0;
    cmp_ready_o = 1'b0;
    take_o      = 1'b0;
    case (st_q)
      ST_HDR: begin
        byte_v_o = 1'b1;
        byte_d_o = hdr_byte(idx_q);
      end
      ST_PAY: begin
        byte_v_o    = cmp_valid_i;
        byte_d_o    = cmp_data_i;
        cmp_ready_o = byte_rdy_i;
      end
      ST_FTR: begin
        byte_v_o    = snap_vld_i;
        byte_d_o    = ftr_w[8*int'(idx_q) +: 8];
        byte_last_o = (int'(idx_q) == FTR_BYTES-1);
        take_o      = snap_vld_i && byte_rdy_i && byte_last_o;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (cmp_valid_i) begin
          st_q  <= ST_HDR;
          idx_q <= '0;
        end
        ST_HDR: if (byte_rdy_i) begin
          if (int'(idx_q) == HDR_BYTES-1) begin
            st_q  <= ST_PAY;
            idx_q <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_PAY: if (cmp_valid_i && byte_rdy_i && cmp_last_i) st_q <= ST_FTR;
        ST_FTR: if (snap_vld_i && byte_rdy_i) begin
          if (int'(idx_q) == FTR_BYTES-1) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  no_early_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_ready_o |-> (st_q == ST_PAY));
endmodule

// File: rtl/gz_word_pack.sv
module gz_word_pack #(
  parameter int WORD_BYTES = 4,
  localparam int CNT_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    byte_v_i,
  input  logic [7:0]              byte_d_i,
  input  logic                    byte_last_i,
  output logic                    byte_rdy_o,
  input  logic                    m_tready_i,
  output logic                    m_tvalid_o,
  output logic [8*WORD_BYTES-1:0] m_tdata_o,
  output logic [WORD_BYTES-1:0]   m_tkeep_o,
  output logic                    m_tlast_o
);
  logic [WORD_BYTES-1:0][7:0] acc_q, word_n, data_q;
  logic [WORD_BYTES-1:0]      keep_n, keep_q;
  logic [CNT_W-1:0]           cnt_q;
  logic                       vld_q, last_q, take, flush;

  assign byte_rdy_o = !vld_q || m_tready_i;
  assign take       = byte_v_i && byte_rdy_o;
  assign flush      = byte_last_i || (cnt_q == CNT_W'(WORD_BYTES-1));

  // lane k: earlier bytes from acc, current byte at cnt, nothing above
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign word_n[k] = (k < int'(cnt_q)) ? acc_q[k] :
                       (k == int'(cnt_q)) ? byte_d_i : 8'h00;
    assign keep_n[k] = (k <= int'(cnt_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
      keep_q <= '0;
      last_q <= 1'b0;
    end else begin
      if (take && flush) begin
        vld_q  <= 1'b1;
        data_q <= word_n;
        keep_q <= keep_n;
        last_q <= byte_last_i;
        acc_q  <= '0;
        cnt_q  <= '0;
      end else begin
        if (m_tready_i) vld_q <= 1'b0;
        if (take) begin
          acc_q[cnt_q] <= byte_d_i;
          cnt_q        <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign m_tvalid_o = vld_q;
  assign m_tdata_o  = data_q;
  assign m_tkeep_o  = keep_q;
  assign m_tlast_o  = last_q;

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !m_tready_i) |=> (vld_q && $stable(data_q) && $stable(keep_q) && $stable(last_q)));

  // R6
  full_keep_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !last_q) |-> (keep_q == '1));

  // R6
  keep_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (keep_q[0] && (((keep_q + 1'b1) & keep_q) == '0)));
endmodule

// File: rtl/gz_stream_framer.sv
module gz_stream_framer #(
  parameter int          WORD_BYTES = 4,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    raw_valid_i,
  input  logic [7:0]              raw_data_i,
  input  logic                    raw_last_i,
  input  logic                    cmp_valid_i,
  input  logic [7:0]              cmp_data_i,
  input  logic                    cmp_last_i,
  output logic                    cmp_ready_o,
  input  logic                    m_tready_i,
  output logic                    m_tvalid_o,
  output logic [8*WORD_BYTES-1:0] m_tdata_o,
  output logic [WORD_BYTES-1:0]   m_tkeep_o,
  output logic                    m_tlast_o
);
  logic        snap_vld, take;
  logic [31:0] snap_crc, snap_len;
  logic        byte_v, byte_last, byte_rdy;
  logic [7:0]  byte_d;

  gz_crc_len #(.POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni,
    .raw_valid_i, .raw_data_i, .raw_last_i,
    .take_i     (take),
    .snap_vld_o (snap_vld),
    .snap_crc_o (snap_crc),
    .snap_len_o (snap_len)
  );

  gz_frame_seq u_seq (
    .clk_i, .rst_ni,
    .cmp_valid_i, .cmp_data_i, .cmp_last_i, .cmp_ready_o,
    .snap_vld_i  (snap_vld),
    .snap_crc_i  (snap_crc),
    .snap_len_i  (snap_len),
    .take_o      (take),
    .byte_v_o    (byte_v),
    .byte_d_o    (byte_d),
    .byte_last_o (byte_last),
    .byte_rdy_i  (byte_rdy)
  );

  gz_word_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk_i, .rst_ni,
    .byte_v_i    (byte_v),
    .byte_d_i    (byte_d),
    .byte_last_i (byte_last),
    .byte_rdy_o  (byte_rdy),
    .m_tready_i, .m_tvalid_o, .m_tdata_o, .m_tkeep_o, .m_tlast_o
  );
endmodule

// File: tb/gz_stream_framer_bench.sv
module gz_stream_framer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        raw_valid_i = 1'b0, raw_last_i = 1'b0;
  logic [7:0]  raw_data_i = 8'h00;
  logic        cmp_valid_i = 1'b0, cmp_last_i = 1'b0;
  logic [7:0]  cmp_data_i = 8'h00;
  logic        cmp_ready_o;
  logic        m_tready_i = 1'b0;
  logic        m_tvalid_o, m_tlast_o;
  logic [31:0] m_tdata_o;
  logic [3:0]  m_tkeep_o;

  int checks = 0, fails = 0;
  logic finished = 1'b0;
  logic [7:0] exp_b [0:255];

  always #5 clk_i = ~clk_i;

  gz_stream_framer u_gz_stream_framer (.*);

  // {cmp_len, raw_len, raw_delay, ready_mask, seed, mode}
  // mode 0: free-running raw stream, 1: raw last byte tied to the final payload accept,
  // mode 2: raw bytes "123456789"
  localparam logic [63:0] VEC [8] = '{
    {16'd1,  16'd32,  8'd0,  8'hFF, 8'd1, 8'd0},  // 19 bytes -> keep 0111
    {16'd2,  16'd40,  8'd0,  8'hFF, 8'd2, 8'd0},  // 20 -> 1111
    {16'd3,  16'd33,  8'd0,  8'hFF, 8'd3, 8'd0},  // 21 -> 0001
    {16'd4,  16'd50,  8'd0,  8'hFF, 8'd4, 8'd0},  // 22 -> 0011
    {16'd13, 16'd5,   8'd0,  8'h5A, 8'd5, 8'd0},  // backpressure
    {16'd20, 16'd100, 8'd30, 8'hFF, 8'd6, 8'd0},  // raw ends late
    {16'd6,  16'd8,   8'd0,  8'hFF, 8'd7, 8'd1},  // same-cycle ends
    {16'd9,  16'd9,   8'd0,  8'hB3, 8'd8, 8'd2}   // known CRC
  };

  function automatic logic [7:0] cbyte(input int sd, input int i);
    return 8'((i*29) + sd*13 + (i >> 2));
  endfunction

  function automatic logic [7:0] rbyte(input int md, input int sd, input int i);
    return (md == 2) ? 8'(8'h31 + i) : 8'((i*71) ^ (sd*17 + 5));
  endfunction

  function automatic logic [31:0] ref_crc(input int md, input int sd, input int n);
    logic [31:0] c;
    logic [7:0]  d;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      d = rbyte(md, sd, i);
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ d[b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic check(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [63:0] v);
    int cl, rl, dl, md, sd, tot, ci, ri, bi, rem;
    logic [7:0]  mk;
    logic [31:0] crc, ew;
    logic [3:0]  ek;
    logic        el, ok, done, stall_p;
    logic [37:0] held;
    cl = int'(v[63:48]); rl = int'(v[47:32]); dl = int'(v[31:24]);
    mk = v[23:16]; sd = int'(v[15:8]); md = int'(v[7:0]);
    tot = 10 + cl + 8;
    crc = (md == 2) ? 32'hCBF43926 : ref_crc(md, sd, rl);  // R3
    exp_b[0] = 8'h1F; exp_b[1] = 8'h8B; exp_b[2] = 8'h08;  // R1
    for (int i = 3; i < 9; i++) exp_b[i] = 8'h00;
    exp_b[9] = 8'hFF;
    for (int i = 0; i < cl; i++) exp_b[10+i] = cbyte(sd, i);  // R2
    for (int i = 0; i < 4; i++) begin
      exp_b[10+cl+i] = crc[8*i +: 8];
      exp_b[14+cl+i] = 8'(rl >> (8*i));  // R4
    end
    ci = 0; ri = 0; bi = 0; done = 1'b0; stall_p = 1'b0; held = '0;
    for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
      @(negedge clk_i);
      m_tready_i  = mk[cyc % 8];
      cmp_valid_i = (ci < cl);
      cmp_data_i  = cbyte(sd, ci);
      cmp_last_i  = (ci == cl - 1);
      raw_valid_i = 1'b0; raw_last_i = 1'b0; raw_data_i = 8'h00;
      if (md != 1) begin
        if (cyc >= dl && ri < rl && (cyc % 5) != 4) begin
          raw_valid_i = 1'b1; raw_data_i = rbyte(md, sd, ri); raw_last_i = (ri == rl - 1);
        end
      end else if (ri < rl - 1) begin
        raw_valid_i = 1'b1; raw_data_i = rbyte(md, sd, ri);
      end
      #1;
      // R1: header goes out before any payload byte is taken
      if (cyc == 0) check(!cmp_ready_o, "R1 cmp_ready in idle", 64'(cmp_ready_o), 64'd0);
      // R7: stalled beat unchanged
      if (stall_p)
        check(m_tvalid_o && {m_tdata_o, m_tkeep_o, m_tlast_o} == {held[36:0]},
              "R7 hold under stall", {m_tvalid_o, m_tdata_o, m_tkeep_o, m_tlast_o},
              {1'b1, held[36:0]});
      // R9: last raw byte in the very cycle the final payload byte is accepted
      if (md == 1 && ri == rl - 1 && cmp_valid_i && cmp_ready_o && cmp_last_i) begin
        raw_valid_i = 1'b1; raw_data_i = rbyte(md, sd, ri); raw_last_i = 1'b1;
      end
      if (raw_valid_i) ri++;
      if (cmp_valid_i && cmp_ready_o) ci++;
      if (m_tvalid_o && m_tready_i) begin
        // R5 R6: byte order, keep and last per beat
        rem = tot - bi;
        ek  = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
        el  = (rem <= 4);
        ew  = '0;
        for (int k = 0; k < 4; k++) if (k < rem) ew[8*k +: 8] = exp_b[bi+k];
        ok = (m_tkeep_o == ek) && (m_tlast_o == el);
        for (int k = 0; k < 4; k++)
          if (k < rem && m_tdata_o[8*k +: 8] != ew[8*k +: 8]) ok = 1'b0;
        check(ok, $sformatf("R2/R3/R4/R5/R6 beat at byte %0d", bi),
              {27'h0, m_tdata_o, m_tkeep_o, m_tlast_o}, {27'h0, ew, ek, el});
        bi += 4;
        if (m_tlast_o) done = 1'b1;
        stall_p = 1'b0;
      end else if (m_tvalid_o) begin
        stall_p = 1'b1;
        held = {1'b1, m_tdata_o, m_tkeep_o, m_tlast_o};
      end else stall_p = 1'b0;
    end
    @(negedge clk_i);
    cmp_valid_i = 1'b0; raw_valid_i = 1'b0; raw_last_i = 1'b0; cmp_last_i = 1'b0;
    check(done && bi >= tot, "R6 packet completed with tlast", 64'(bi), 64'(tot));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    check(!m_tvalid_o && !cmp_ready_o, "R10 outputs under reset",
          {62'h0, m_tvalid_o, cmp_ready_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!m_tvalid_o && !cmp_ready_o, "R10 outputs after reset",
          {62'h0, m_tvalid_o, cmp_ready_o}, 64'd0);
    // R8: packets run back to back, each trailer checked against its own raw bytes
    for (int n = 0; n < 8; n++) run_vec(VEC[n]);
    // R8: repeat of an earlier packet after others must give the same trailer
    run_vec(VEC[0]);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule